// File: doc/BRIEF.md
# Four-Team Quiz Buzzer Controller

This block runs one round of a four-team quiz. Each team has one answer button. The host first clears the round and then arms it with a start strobe. The first team to press after the round is armed is latched. That team's lamp lights and its number is reported. Every later press from any team is then ignored until the host clears the round again. A winning press also starts a beeper that alternates between two tones for a fixed number of cycles.

A press made before the start strobe is a foul. So is a press made after the answer window has closed with no winner. In both cases the offending team's number is reported and the foul output, which drives a warning horn, is raised. Button inputs may be asynchronous: each one passes through a two-stage synchronizer, and only its rising edge counts as a press.

Top module: `quiz_buzzer`

## Requirements
- R1: After `rst_n` is low, or in the cycle after a `host_clear` pulse, `team_id` is 0, `team_lamp` is 0, `foul` is 0 and `beep` is 0.
- R2: When a round is armed by `host_go` and a team presses, the round is won. `team_id` then shows the team as 1 to 4 (bit i of `btn` is team i+1), `team_lamp` has only bit i set, and `foul` stays 0. The result appears on the third rising clock edge after the button rises.
- R3: If several buttons rise in the same cycle, the team with the lowest bit index is latched.
- R4: Once a win or a foul is latched, further presses from any team change neither `team_id`, `team_lamp` nor `foul` until `host_clear`.
- R5: For `BEEP_CYC` cycles after a win, `beep` produces a square wave. It alternates every `TONE_ALT_CYC` cycles between a half period of `TONE_A_HALF` and a half period of `TONE_B_HALF`. Afterwards `beep` stays 0.
- R6: A press after `host_clear` but before `host_go` is an early foul. `foul` goes to 1, `team_id` shows the pressing team, and `team_lamp` stays 0.
- R7: If no team presses within `WINDOW_CYC` cycles after `host_go`, the window closes. A later press is then a late foul, reported as in R6.
- R8: A button already held down when the round is cleared and armed does not count as a press. It counts only after it is released and pressed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| host_clear | input | 1 | Host reset of the round (synchronous) |
| host_go | input | 1 | Host start strobe that arms the round |
| btn | input | 4 | Team buttons, bit i is team i+1, asynchronous |
| team_lamp | output | 4 | One-hot lamp of the winning team |
| team_id | output | 3 | Latched team number 1 to 4, 0 for none |
| foul | output | 1 | Foul report and warning horn drive |
| beep | output | 1 | Two-tone beeper output |

## Verification
The round state is visible at the ports. A wrong state transition shows up as a wrong `team_id` or `foul` three edges after the offending button edge. A broken lockout shows up as a change in `team_id` three edges after a losing press. A faulty tone generator shows up as half-period run lengths on `beep` that match neither tone length, or as activity after `BEEP_CYC` cycles. A lost synchronizer edge shows up as a latched result from a button that was held through the clear.

// File: rtl/quiz_buzzer.sv
module quiz_buzzer #(
  parameter int WINDOW_CYC   = 500_000_000,
  parameter int BEEP_CYC     = 125_000_000,
  parameter int TONE_A_HALF  = 25_000,
  parameter int TONE_B_HALF  = 16_667,
  parameter int TONE_ALT_CYC = 6_250_000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_clear,
  input  logic       host_go,
  input  logic [3:0] btn,
  output logic [3:0] team_lamp,
  output logic [2:0] team_id,
  output logic       foul,
  output logic       beep
);
  localparam int WW = $clog2(WINDOW_CYC + 1);
  localparam int BW = $clog2(BEEP_CYC + 1);
  localparam int HMAX = (TONE_A_HALF > TONE_B_HALF) ? TONE_A_HALF : TONE_B_HALF;
  localparam int TW = $clog2(HMAX + 1);
  localparam int AW = $clog2(TONE_ALT_CYC + 1);

  typedef enum logic [2:0] {S_IDLE, S_ARMED, S_WON, S_FOUL, S_CLOSED} st_t;

  st_t           st;
  logic [2:0]    id_q;
  logic [WW-1:0] win_cnt;
  logic [3:0]    sy1, sy2, sy3;
  logic [3:0]    press;
  logic          any_press, win_now;
  logic [2:0]    pick;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0; sy2 <= '0; sy3 <= '0;
    end else begin
      sy1 <= btn; sy2 <= sy1; sy3 <= sy2;
    end

  assign press     = sy2 & ~sy3;
  assign any_press = |press;
  assign pick      = press[0] ? 3'd1 : press[1] ? 3'd2 : press[2] ? 3'd3 : 3'd4;
  assign win_now   = !host_clear && st == S_ARMED && any_press;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; id_q <= '0; win_cnt <= '0;
    end else if (host_clear) begin
      st <= S_IDLE; id_q <= '0; win_cnt <= '0;
    end else begin
      case (st)
        S_IDLE:
          if (any_press) begin
            st <= S_FOUL; id_q <= pick;
          end else if (host_go) begin
            st <= S_ARMED; win_cnt <= '0;
          end
        S_ARMED:
          if (any_press) begin
            st <= S_WON; id_q <= pick;
          end else if (win_cnt == WW'(WINDOW_CYC - 1)) begin
            st <= S_CLOSED;
          end else begin
            win_cnt <= win_cnt + 1'b1;
          end
        S_CLOSED:
          if (any_press) begin
            st <= S_FOUL; id_q <= pick;
          end
        default: st <= st;
      endcase
    end

  logic [BW-1:0] beep_left;
  logic [TW-1:0] tone_cnt, half_lim;
  logic [AW-1:0] alt_cnt;
  logic          tone, phase;

  assign half_lim = phase ? TW'(TONE_B_HALF - 1) : TW'(TONE_A_HALF - 1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      beep_left <= '0; tone <= 1'b0; phase <= 1'b0; tone_cnt <= '0; alt_cnt <= '0;
    end else if (host_clear) begin
      beep_left <= '0; tone <= 1'b0;
    end else if (win_now) begin
      beep_left <= BW'(BEEP_CYC);
      tone <= 1'b0; phase <= 1'b0; tone_cnt <= '0; alt_cnt <= '0;
    end else if (beep_left != '0) begin
      beep_left <= beep_left - 1'b1;
      if (alt_cnt == AW'(TONE_ALT_CYC - 1)) begin
        alt_cnt <= '0; phase <= ~phase; tone_cnt <= '0;
      end else begin
        alt_cnt <= alt_cnt + 1'b1;
        if (tone_cnt == half_lim) begin
          tone_cnt <= '0; tone <= ~tone;
        end else begin
          tone_cnt <= tone_cnt + 1'b1;
        end
      end
    end

  assign beep      = (beep_left != '0) && tone;
  assign team_id   = id_q;
  assign foul      = (st == S_FOUL);
  assign team_lamp = (st == S_WON) ? (4'd1 << (id_q - 3'd1)) : 4'd0;

  a_r2_lamp_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(team_lamp));
  a_r4_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (foul || team_lamp != 4'd0) && !host_clear |=> $stable(team_id) && team_id != 3'd0);
  a_r6_foul_reports_team: assert property (@(posedge clk) disable iff (!rst_n)
    foul |-> team_id != 3'd0 && team_lamp == 4'd0);
  a_r5_quiet_without_win: assert property (@(posedge clk) disable iff (!rst_n)
    team_lamp == 4'd0 |-> !beep);
  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    host_clear |=> team_id == 3'd0 && !foul && team_lamp == 4'd0);
endmodule

// File: tb/quiz_buzzer_tb_top.sv
module quiz_buzzer_tb_top;
  localparam int WIN = 40, BEEP = 100, HA = 3, HB = 5, ALT = 24;

  logic clk = 1'b0, rst_n = 1'b0, host_clear = 1'b0, host_go = 1'b0;
  logic [3:0] btn = 4'd0;
  logic [3:0] team_lamp;
  logic [2:0] team_id;
  logic foul, beep;
  int checks = 0, failures = 0;
  logic [3:0] exp_q[$];
  logic [2:0] prev_id = 3'd0;
  bit done = 0;

  always #2.5 clk = ~clk;

  quiz_buzzer #(.WINDOW_CYC(WIN), .BEEP_CYC(BEEP), .TONE_A_HALF(HA),
                .TONE_B_HALF(HB), .TONE_ALT_CYC(ALT)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_clear(host_clear), .host_go(host_go),
    .btn(btn), .team_lamp(team_lamp), .team_id(team_id), .foul(foul), .beep(beep));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clear_round();
    @(negedge clk) host_clear = 1'b1;
    @(negedge clk) host_clear = 1'b0;
  endtask

  task automatic start_round();
    @(negedge clk) host_go = 1'b1;
    @(negedge clk) host_go = 1'b0;
  endtask

  task automatic push_press(input logic [3:0] mask, input logic f, input logic [2:0] id);
    exp_q.push_back({f, id});
    @(negedge clk) btn = mask;
    cyc(5);
    btn = 4'd0;
    cyc(2);
  endtask

  always @(negedge clk) begin
    if (rst_n && prev_id == 3'd0 && team_id != 3'd0) begin
      if (exp_q.size() == 0)
        chk(0, "R2/R6 unexpected result", int'({foul, team_id}), 0);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk({foul, team_id} == e, "R2/R3/R6/R7 scoreboard", int'({foul, team_id}), int'(e));
      end
    end
    prev_id = team_id;
  end

  initial begin
    cyc(2000);
    if (!done) begin
      chk(0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    cyc(3);
    chk(team_id == 0 && team_lamp == 0 && !foul && !beep, "R1 reset", int'(team_id), 0);
    rst_n = 1'b1;
    cyc(2);
    clear_round();
    start_round();
    cyc(3);
    chk(team_id == 0, "R2 armed no result", int'(team_id), 0);
    begin
      int run; bit last, sawa, sawb, bad;
      run = 0; last = 0; sawa = 0; sawb = 0; bad = 0;
      exp_q.push_back({1'b0, 3'd3});
      @(negedge clk) btn = 4'b0100;
      cyc(2);
      chk(team_id == 0, "R2 latency before third edge", int'(team_id), 0);
      for (int i = 0; i < BEEP + 30; i++) begin
        @(negedge clk);
        if (i == 3) btn = 4'd0;
        if (i == 0) chk(team_lamp == 4'b0100, "R2 lamp", int'(team_lamp), 4);
        if (i < BEEP) begin
          if (beep != last) begin
            if (run == HA) sawa = 1;
            if (run == HB) sawb = 1;
            run = 1; last = beep;
          end else run++;
        end else if (beep) bad = 1;
      end
      chk(sawa && sawb, "R5 two tones", int'({sawa, sawb}), 3);
      chk(!bad, "R5 silent after beep time", int'(bad), 0);
    end
    @(negedge clk) btn = 4'b0001;
    cyc(6);
    chk(team_id == 3 && team_lamp == 4'b0100 && !foul, "R4 lockout after win", int'(team_id), 3);
    btn = 4'd0;
    clear_round();
    chk(team_id == 0 && team_lamp == 0 && !foul && !beep, "R1 host clear", int'(team_id), 0);
    start_round();
    push_press(4'b1010, 1'b0, 3'd2);
    chk(team_lamp == 4'b0010, "R3 lowest wins", int'(team_lamp), 2);
    clear_round();
    push_press(4'b1000, 1'b1, 3'd4);
    chk(foul && team_lamp == 0, "R6 early foul", int'(foul), 1);
    @(negedge clk) btn = 4'b0001;
    cyc(6);
    btn = 4'd0;
    chk(team_id == 4 && foul, "R4 lockout after foul", int'(team_id), 4);
    clear_round();
    start_round();
    cyc(WIN + 10);
    chk(team_id == 0 && !foul, "R7 window closed no result", int'(team_id), 0);
    push_press(4'b0001, 1'b1, 3'd1);
    chk(foul && team_id == 1, "R7 late foul", int'(team_id), 1);
    @(negedge clk) btn = 4'b0010;
    cyc(4);
    clear_round();
    start_round();
    cyc(10);
    chk(team_id == 0 && !foul, "R8 held button ignored", int'(team_id), 0);
    btn = 4'd0;
    cyc(3);
    push_press(4'b0010, 1'b0, 3'd2);
    chk(team_id == 2 && team_lamp == 4'b0010, "R8 fresh press wins", int'(team_id), 2);
    cyc(2);
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule